// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block sits between an interrupt priority resolver and the processor. It raises an interrupt request toward the CPU whenever the resolver reports a pending winner. It then follows the CPU's active-low acknowledge strobes, counts them and places the right byte on an 8-bit data bus while each strobe is low. At the start of the sequence it emits one-cycle pulses that mark the winning level as in service and clear its request.

Two processor styles are served. In the 16-bit style the sequence has two strobes. The first strobe only captures the level, and the second strobe returns a type vector. In the 8-bit style the sequence has three strobes, which return a call opcode followed by a 16-bit handler address. In automatic end-of-interrupt mode, the in-service mark is cleared by a pulse as the final strobe ends. In the normal mode the mark is left for a later end-of-interrupt command, which this block does not handle.

Top module: `intack_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `data_oe`, `isr_set`, `isr_clr` and `req_clr` are 0.
- R2: `int_out` equals `win_valid` whenever no acknowledge sequence is in progress. It is 0 from the cycle after the first strobe falls until the cycle after the last strobe rises.
- R3: With `cfg_cpu16`=1 a sequence is two strobes. `data_oe` stays 0 during the first. During the second the bus carries `{cfg_vec_hi[7:3], level}`.
- R4: With `cfg_cpu16`=0 a sequence is three strobes. They carry 0xCD, then the low address byte, then `cfg_vec_hi`.
- R5: With `cfg_int4`=1 the low address byte is `{cfg_addr_lo[2:0], level[2:0], 2'b00}`.
- R6: With `cfg_int4`=0 the low address byte is `{cfg_addr_lo[2:1], level[2:0], 3'b000}`.
- R7: One cycle after the first strobe falls, and only if `win_valid` was 1 when it fell, `isr_set` and `req_clr` pulse high for exactly one cycle. `ack_level` shows the captured level from then on.
- R8: One cycle after the last strobe rises, `isr_clr` pulses for one cycle if automatic end-of-interrupt was selected and the request was genuine. Otherwise `isr_clr` stays 0.
- R9: `data_oe` is 1 only in the cycles after the fall of a byte-driving strobe. It returns to 0 in the cycle after that strobe rises.
- R10: If `win_valid` is 0 when the first strobe falls, the captured level is 7 and no `isr_set`/`req_clr` pulse occurs.
- R11: The CPU style, the end-of-interrupt mode and the level are captured at the first strobe. Changes to `cfg_cpu16`, `cfg_aeoi`, `win_level` or `win_valid` later in the sequence have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inta_n | input | 1 | Active-low acknowledge strobe from the CPU, synchronous to clk |
| win_valid | input | 1 | Resolver reports a pending winner |
| win_level | input | 3 | Winning level number |
| cfg_cpu16 | input | 1 | 1: two-strobe type-vector style, 0: three-strobe call style |
| cfg_aeoi | input | 1 | Automatic end-of-interrupt enable |
| cfg_int4 | input | 1 | Call address spacing: 1 = 4 bytes, 0 = 8 bytes |
| cfg_vec_hi | input | 8 | Vector bits 7:3 (16-bit style) or handler address high byte |
| cfg_addr_lo | input | 3 | Handler address bits 7:5 |
| int_out | output | 1 | Interrupt request toward the CPU |
| data_out | output | 8 | Byte returned on the data bus |
| data_oe | output | 1 | Data bus drive enable |
| isr_set | output | 1 | Pulse: mark `ack_level` in service |
| req_clr | output | 1 | Pulse: clear the request of `ack_level` |
| isr_clr | output | 1 | Pulse: automatic end-of-interrupt for `ack_level` |
| ack_level | output | 3 | Level captured for the current sequence |

## Verification
The bench changes the CPU style, the end-of-interrupt mode and the winning level between strobes of a sequence. A design that samples these live instead of capturing them would return a mixed vector, stop after the wrong strobe, or clear the wrong level. Spurious sequences check that the design falls back to level 7 and emits no in-service pulse; a design that ignored `win_valid` would mark a phantom level. Both address spacings are exercised to expose shifted level fields. The bench also samples the drive enable on the first strobe of the 16-bit style and after each rising strobe, so that bus contention or a stuck enable shows up there.

// File: rtl/intack_pkg.sv
package intack_pkg;

    localparam int LVL_W  = 3;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_THIRD  = 2'd2
    } phase_e;

    typedef struct packed {
        logic             mode16;
        logic             aeoi;
        logic             valid;
        logic [LVL_W-1:0] lvl;
    } seq_ctx_t;

    function automatic logic is_last(input logic mode16, input phase_e ph);
        return mode16 ? (ph == PH_SECOND) : (ph == PH_THIRD);
    endfunction

    function automatic phase_e next_phase(input phase_e ph);
        case (ph)
            PH_FIRST:  return PH_SECOND;
            PH_SECOND: return PH_THIRD;
            default:   return PH_FIRST;
        endcase
    endfunction

    function automatic logic drives_bus(input logic mode16, input phase_e ph);
        return !(mode16 && ph == PH_FIRST);
    endfunction

    function automatic logic [BYTE_W-1:0] ack_byte(
        input logic              mode16,
        input phase_e            ph,
        input logic [LVL_W-1:0]  lvl,
        input logic              int4,
        input logic [BYTE_W-1:0] vec_hi,
        input logic [2:0]        addr_lo,
        input logic [BYTE_W-1:0] call_op
    );
        logic [BYTE_W-1:0] b;
        b = '0;
        if (mode16) begin
            if (ph == PH_SECOND) b = {vec_hi[7:3], lvl};
        end else begin
            case (ph)
                PH_FIRST:  b = call_op;
                PH_SECOND: b = int4 ? {addr_lo, lvl, 2'b00}
                                    : {addr_lo[2:1], lvl, 3'b000};
                default:   b = vec_hi;
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/intack_strobe.sv
module intack_strobe
    import intack_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strb_n,
    output logic strb_q,
    output logic fall,
    output logic rise
);
    always_ff @(posedge clk) begin
        if (rst) strb_q <= 1'b1;
        else     strb_q <= strb_n;
    end

    assign fall = strb_q & ~strb_n;
    assign rise = ~strb_q & strb_n;
endmodule

// File: rtl/intack_ctrl.sv
module intack_ctrl
    import intack_pkg::*;
#(
    parameter logic [LVL_W-1:0] SPUR_LEVEL = 3'd7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall,
    input  logic             rise,
    input  logic             win_valid,
    input  logic [LVL_W-1:0] win_level,
    input  logic             cfg_cpu16,
    input  logic             cfg_aeoi,
    output phase_e           phase,
    output logic             cur_mode16,
    output logic [LVL_W-1:0] cur_lvl,
    output logic             active,
    output logic             isr_set,
    output logic             req_clr,
    output logic             isr_clr,
    output logic [LVL_W-1:0] ack_level
);
    phase_e   phase_q;
    seq_ctx_t ctx_q;
    seq_ctx_t ctx_now;

    always_comb begin
        if (phase_q == PH_FIRST) begin
            ctx_now.mode16 = cfg_cpu16;
            ctx_now.aeoi   = cfg_aeoi;
            ctx_now.valid  = win_valid;
            ctx_now.lvl    = win_valid ? win_level : SPUR_LEVEL;
        end else begin
            ctx_now = ctx_q;
        end
    end

    assign phase      = phase_q;
    assign cur_mode16 = ctx_now.mode16;
    assign cur_lvl    = ctx_now.lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_FIRST;
            ctx_q     <= '0;
            active    <= 1'b0;
            isr_set   <= 1'b0;
            req_clr   <= 1'b0;
            isr_clr   <= 1'b0;
            ack_level <= '0;
        end else begin
            isr_set <= 1'b0;
            req_clr <= 1'b0;
            isr_clr <= 1'b0;
            if (fall && phase_q == PH_FIRST) begin
                ctx_q     <= ctx_now;
                active    <= 1'b1;
                isr_set   <= ctx_now.valid;
                req_clr   <= ctx_now.valid;
                ack_level <= ctx_now.lvl;
            end
            if (rise && active) begin
                if (is_last(ctx_q.mode16, phase_q)) begin
                    phase_q <= PH_FIRST;
                    active  <= 1'b0;
                    isr_clr <= ctx_q.aeoi & ctx_q.valid;
                end else begin
                    phase_q <= next_phase(phase_q);
                end
            end
        end
    end

    // R4
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q != 2'd3);

    // R7
    set_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        isr_set |=> !isr_set);

    // R8
    clr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        isr_clr |-> !active);
endmodule

// File: rtl/intack_bytegen.sv
module intack_bytegen
    import intack_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CALL_OPCODE = 8'hCD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              unload,
    input  logic              mode16,
    input  phase_e            phase,
    input  logic [LVL_W-1:0]  lvl,
    input  logic              int4,
    input  logic [BYTE_W-1:0] vec_hi,
    input  logic [2:0]        addr_lo,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
            data_oe  <= 1'b0;
        end else if (load) begin
            data_out <= ack_byte(mode16, phase, lvl, int4, vec_hi, addr_lo, CALL_OPCODE);
            data_oe  <= drives_bus(mode16, phase);
        end else if (unload) begin
            data_oe  <= 1'b0;
        end
    end
endmodule

// File: rtl/intack_seq.sv
module intack_seq
    import intack_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CALL_OPCODE = 8'hCD,
    parameter logic [LVL_W-1:0]  SPUR_LEVEL  = 3'd7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inta_n,
    input  logic              win_valid,
    input  logic [LVL_W-1:0]  win_level,
    input  logic              cfg_cpu16,
    input  logic              cfg_aeoi,
    input  logic              cfg_int4,
    input  logic [BYTE_W-1:0] cfg_vec_hi,
    input  logic [2:0]        cfg_addr_lo,
    output logic              int_out,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe,
    output logic              isr_set,
    output logic              req_clr,
    output logic              isr_clr,
    output logic [LVL_W-1:0]  ack_level
);
    logic             strb_q;
    logic             fall;
    logic             rise;
    phase_e           phase;
    logic             cur_mode16;
    logic [LVL_W-1:0] cur_lvl;
    logic             active;

    intack_strobe u_strobe (
        .clk    (clk),
        .rst    (rst),
        .strb_n (inta_n),
        .strb_q (strb_q),
        .fall   (fall),
        .rise   (rise)
    );

    intack_ctrl #(.SPUR_LEVEL(SPUR_LEVEL)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .fall       (fall),
        .rise       (rise),
        .win_valid  (win_valid),
        .win_level  (win_level),
        .cfg_cpu16  (cfg_cpu16),
        .cfg_aeoi   (cfg_aeoi),
        .phase      (phase),
        .cur_mode16 (cur_mode16),
        .cur_lvl    (cur_lvl),
        .active     (active),
        .isr_set    (isr_set),
        .req_clr    (req_clr),
        .isr_clr    (isr_clr),
        .ack_level  (ack_level)
    );

    intack_bytegen #(.CALL_OPCODE(CALL_OPCODE)) u_bytes (
        .clk      (clk),
        .rst      (rst),
        .load     (fall),
        .unload   (rise),
        .mode16   (cur_mode16),
        .phase    (phase),
        .lvl      (cur_lvl),
        .int4     (cfg_int4),
        .vec_hi   (cfg_vec_hi),
        .addr_lo  (cfg_addr_lo),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

    assign int_out = win_valid & ~active;

    // R9
    oe_strobe_low_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !$past(inta_n));

    // R2
    no_req_while_drive_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !int_out);

    // R8
    clr_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
        isr_clr |-> ($past(inta_n) && !strb_q == 1'b0));
endmodule

// File: tb/intack_seq_tb.sv
module intack_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inta_n = 1'b1;
    logic       win_valid = 1'b0;
    logic [2:0] win_level = '0;
    logic       cfg_cpu16 = 1'b0;
    logic       cfg_aeoi = 1'b0;
    logic       cfg_int4 = 1'b0;
    logic [7:0] cfg_vec_hi = '0;
    logic [2:0] cfg_addr_lo = '0;
    logic       int_out;
    logic [7:0] data_out;
    logic       data_oe;
    logic       isr_set;
    logic       req_clr;
    logic       isr_clr;
    logic [2:0] ack_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    intack_seq u_dut (
        .clk (clk), .rst (rst), .inta_n (inta_n),
        .win_valid (win_valid), .win_level (win_level),
        .cfg_cpu16 (cfg_cpu16), .cfg_aeoi (cfg_aeoi), .cfg_int4 (cfg_int4),
        .cfg_vec_hi (cfg_vec_hi), .cfg_addr_lo (cfg_addr_lo),
        .int_out (int_out), .data_out (data_out), .data_oe (data_oe),
        .isr_set (isr_set), .req_clr (req_clr), .isr_clr (isr_clr),
        .ack_level (ack_level)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_byte(input bit m16, input int p, input logic [2:0] l,
                                            input bit i4, input logic [7:0] hi, input logic [2:0] lo);
        if (m16) return (p == 1) ? {hi[7:3], l} : 8'h00;
        if (p == 0) return 8'hCD;
        if (p == 1) return i4 ? {lo, l, 2'b00} : {lo[2:1], l, 3'b000};
        return hi;
    endfunction

    task automatic run_seq(input bit m16, input bit ae, input bit i4, input logic [7:0] hi,
                           input logic [2:0] lo, input logic [2:0] lv, input bit vl);
        int n;
        logic [2:0] el;
        n  = m16 ? 2 : 3;
        el = vl ? lv : 3'd7;
        @(negedge clk);
        cfg_cpu16 = m16; cfg_aeoi = ae; cfg_int4 = i4; cfg_vec_hi = hi; cfg_addr_lo = lo;
        win_level = lv; win_valid = vl;
        @(negedge clk);
        chk("R2 int_out idle", {7'd0, int_out}, {7'd0, vl});
        for (int p = 0; p < n; p++) begin
            inta_n = 1'b0;
            @(negedge clk);
            if (m16 && p == 0) chk("R3 no drive first strobe", {7'd0, data_oe}, 8'd0);
            else chk(m16 ? "R3 oe" : "R4 oe", {7'd0, data_oe}, 8'd1);
            if (data_oe)
                chk(m16 ? "R3 vector" : (p == 1 ? (i4 ? "R5 low byte" : "R6 low byte") : "R4 byte"),
                    data_out, exp_byte(m16, p, el, i4, hi, lo));
            chk("R2 int_out busy", {7'd0, int_out}, 8'd0);
            if (p == 0) begin
                chk(vl ? "R7 isr_set" : "R10 no isr_set", {7'd0, isr_set}, {7'd0, vl});
                chk(vl ? "R7 req_clr" : "R10 no req_clr", {7'd0, req_clr}, {7'd0, vl});
                chk(vl ? "R7 ack_level" : "R10 spurious level", {5'd0, ack_level}, {5'd0, el});
                // R11: disturb inputs after capture
                cfg_cpu16 = $urandom_range(0, 1); cfg_aeoi = $urandom_range(0, 1);
                win_level = 3'($urandom_range(0, 7)); win_valid = $urandom_range(0, 1);
            end
            @(negedge clk);
            chk("R7 pulse width", {6'd0, isr_set, req_clr}, 8'd0);
            inta_n = 1'b1;
            @(negedge clk);
            chk("R9 oe released", {7'd0, data_oe}, 8'd0);
            chk("R8 isr_clr", {7'd0, isr_clr}, {7'd0, (p == n - 1) && ae && vl});
            chk("R11 ack_level held", {5'd0, ack_level}, {5'd0, el});
            @(negedge clk);
            chk("R8 clr pulse width", {7'd0, isr_clr}, 8'd0);
        end
        chk("R2 int_out after", {7'd0, int_out}, {7'd0, win_valid});
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", {7'd0, data_oe}, 8'd0);
        chk("R1 pulses in reset", {5'd0, isr_set, isr_clr, req_clr}, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 oe after reset", {7'd0, data_oe}, 8'd0);
        chk("R1 pulses after reset", {5'd0, isr_set, isr_clr, req_clr}, 8'd0);
        // directed corners
        run_seq(1'b1, 1'b1, 1'b0, 8'hA8, 3'd0, 3'd5, 1'b1);
        run_seq(1'b0, 1'b1, 1'b1, 8'h3C, 3'd7, 3'd6, 1'b1);
        run_seq(1'b0, 1'b0, 1'b0, 8'hF0, 3'd5, 3'd3, 1'b1);
        run_seq(1'b1, 1'b1, 1'b1, 8'h20, 3'd2, 3'd1, 1'b0);
        run_seq(1'b0, 1'b1, 1'b1, 8'h11, 3'd4, 3'd0, 1'b0);
        for (int k = 0; k < 60; k++)
            run_seq($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                    8'($urandom_range(0, 255)), 3'($urandom_range(0, 7)),
                    3'($urandom_range(0, 7)), ($urandom_range(0, 9) != 0));
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule